// File: doc/BRIEF.md
# SDRAM Read Burst Data Pipeline

This block is the read-side timing model inside a controller for a four-bank synchronous DRAM. It sees each decoded command as the controller issues it. From the programmed column latency, the programmed burst length and the per-byte read mask, it predicts for every clock whether the DRAM data bus carries a read beat, which byte lanes hold real data, and which beat of the burst that is. The controller's capture logic uses these three outputs to accept returned read data without a per-access scoreboard.

A read burst can end early in three ways: a burst-stop command, a precharge command, or a newer read. In each case the cut is aligned to the column latency. Beats already on their way out still appear, and nothing from the old burst appears from the cutoff cycle on. The byte mask follows a separate, fixed two-clock path from input to lane qualifier, whatever the column latency.

Top module: `rdp_read_pipe`

## Requirements
- R1: With `cas3` low the first beat of a read shows on `rd_valid` in the cycle after the second clock edge that follows the edge that registered the read. With `cas3` high it shows after the third such edge.
- R2: `burst_code` is sampled with each read. Values 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats on consecutive cycles. Any value with bit 2 set selects full-page mode, which runs until the burst is cut.
- R3: `beat_idx` shows 0 on the first beat of every read and rises by one on each later beat. In full-page mode it wraps from 511 to 0 after 512 columns and the burst keeps going.
- R4: In a cycle with `rd_valid` high, `lane_valid[i]` is the inverse of `byte_mask[i]` as registered two clock edges before the edge that drives the output. In a cycle with `rd_valid` low, `lane_valid` is all zero.
- R5: A burst-stop command (code 2) registered at edge n removes every read beat that would reach the output at edge n+CL or later. Beats due before that edge still appear.
- R6: A precharge command (code 3) registered at edge n cuts the running read burst at edge n+CL, in the same way as R5.
- R7: A read (code 1) registered at edge n during a burst removes the old burst's beats from edge n+CL on, and puts beat 0 of the new burst at that edge. Reads may be issued on every clock.
- R8: No-op (code 0) and codes 4 to 7 do not affect the read burst. Burst-stop and precharge with no read burst running produce no output beat.
- R9: `rst` is synchronous and active high. An edge with `rst` high drops every pending beat, and `rd_valid`, `lane_valid` and `beat_idx` are zero after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | 3 | Decoded command: 0 no-op, 1 read, 2 burst stop, 3 precharge, 4-7 other |
| cas3 | input | 1 | Column latency select: 0 two clocks, 1 three clocks |
| burst_code | input | 3 | Burst length code sampled with a read |
| byte_mask | input | LANES (2) | Read mask per byte lane, high blanks that lane |
| rd_valid | output | 1 | A read beat is on the data bus this cycle |
| lane_valid | output | LANES (2) | Per-lane data valid for the current cycle |
| beat_idx | output | COL_W (9) | Position of the current beat within its burst |

## Verification
Two events can land on the same cycle: the latency-aligned cutoff of one burst and the first beat of the next one, or the cutoff and the natural last beat of a burst. The mask delay can also flip lanes in the very cycle a burst is cut or restarted. The bench provokes these by sweeping both latencies over every burst code, with stop, precharge and interrupting reads placed mid-burst and a mask pattern that changes every clock. A small arithmetic model judges each output cycle: it finds the newest read old enough to have reached the output, looks for any cutting command between that read and the output slot, and takes the lane mask from two edges back.

// File: rtl/sdr_rd_pkg.sv
package sdr_rd_pkg;

  localparam logic [2:0] CMD_NOP  = 3'd0;
  localparam logic [2:0] CMD_READ = 3'd1;
  localparam logic [2:0] CMD_BST  = 3'd2;
  localparam logic [2:0] CMD_PRE  = 3'd3;

  // Bit 2 of the burst code selects the open-ended page burst.
  function automatic logic code_is_page(input logic [2:0] code);
    return code[2];
  endfunction

  // Fixed burst lengths are powers of two selected by the low bits.
  function automatic int code_beats(input logic [2:0] code);
    return 1 << code[1:0];
  endfunction

endpackage

// File: rtl/rdp_issue.sv
module rdp_issue
  import sdr_rd_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic [2:0]       burst_code,
  output logic             iss_vld,
  output logic [COL_W-1:0] iss_beat
);

  logic             run_q;
  logic             page_q;
  logic [COL_W-1:0] pos_q;
  logic [COL_W-1:0] last_q;
  logic             is_read;
  logic             is_cut;

  assign is_read = (cmd == CMD_READ);
  assign is_cut  = (cmd == CMD_BST) || (cmd == CMD_PRE);

  // Beat slot at command time; the latency pipe shifts it to the bus.
  always_comb begin
    iss_vld  = 1'b0;
    iss_beat = '0;
    if (is_read) begin
      iss_vld = 1'b1;
    end else if (!is_cut && run_q) begin
      iss_vld  = 1'b1;
      iss_beat = pos_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      page_q <= 1'b0;
      pos_q  <= '0;
      last_q <= '0;
    end else if (is_read) begin
      page_q <= code_is_page(burst_code);
      last_q <= COL_W'(code_beats(burst_code) - 1);
      pos_q  <= COL_W'(1);
      run_q  <= code_is_page(burst_code) || (code_beats(burst_code) > 1);
    end else if (is_cut) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      pos_q <= pos_q + 1'b1;
      if (!page_q && pos_q == last_q) run_q <= 1'b0;
    end
  end

  p_pos_in_burst_r2: assert property (@(posedge clk) disable iff (rst)
    (run_q && !page_q) |-> (pos_q <= last_q && pos_q != '0));

  p_cut_stops_r5: assert property (@(posedge clk) disable iff (rst)
    is_cut |=> !run_q);

endmodule

// File: rtl/rdp_lat_pipe.sv
module rdp_lat_pipe #(
  parameter int W      = 10,
  parameter int MAX_CL = 3,
  localparam int SEL_W = $clog2(MAX_CL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     in_word,
  input  logic [SEL_W-1:0] sel,
  output logic [W-1:0]     tap
);

  logic [MAX_CL-1:0][W-1:0] taps;

  generate
    for (genvar i = 0; i < MAX_CL; i++) begin : g_stg
      logic [W-1:0] q;
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= in_word;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= g_stg[i-1].q;
        end
      end
      assign taps[i] = q;
    end
  endgenerate

  // Stage sel-1 was loaded sel-1 edges after the command edge.
  always_comb begin
    tap = '0;
    for (int i = 0; i < MAX_CL; i++) begin
      if (int'(sel) == i + 1) tap = taps[i];
    end
  end

  p_sel_legal_r1: assert property (@(posedge clk) disable iff (rst)
    (sel >= SEL_W'(1)) && (int'(sel) <= MAX_CL));

endmodule

// File: rtl/rdp_mask_dly.sv
module rdp_mask_dly #(
  parameter int LANES = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] mask_out
);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_dly
      logic [LANES-1:0] q;
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= mask_in;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (rst) q <= '0;
          else     q <= g_dly[i-1].q;
        end
      end
    end
  endgenerate

  assign mask_out = g_dly[DEPTH-1].q;

endmodule

// File: rtl/rdp_read_pipe.sv
module rdp_read_pipe
  import sdr_rd_pkg::*;
#(
  parameter int LANES  = 2,
  parameter int COL_W  = 9,
  parameter int MAX_CL = 3,
  parameter int MASK_D = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       cmd,
  input  logic             cas3,
  input  logic [2:0]       burst_code,
  input  logic [LANES-1:0] byte_mask,
  output logic             rd_valid,
  output logic [LANES-1:0] lane_valid,
  output logic [COL_W-1:0] beat_idx
);

  localparam int SEL_W  = $clog2(MAX_CL + 1);
  localparam int WORD_W = COL_W + 1;

  logic              iss_vld;
  logic [COL_W-1:0]  iss_beat;
  logic [WORD_W-1:0] tap_word;
  logic [SEL_W-1:0]  lat_sel;
  logic [LANES-1:0]  mask_aged;

  assign lat_sel = cas3 ? SEL_W'(3) : SEL_W'(2);

  rdp_issue #(.COL_W(COL_W)) issue_i (
    .clk       (clk),
    .rst       (rst),
    .cmd       (cmd),
    .burst_code(burst_code),
    .iss_vld   (iss_vld),
    .iss_beat  (iss_beat)
  );

  rdp_lat_pipe #(.W(WORD_W), .MAX_CL(MAX_CL)) lat_i (
    .clk    (clk),
    .rst    (rst),
    .in_word({iss_vld, iss_beat}),
    .sel    (lat_sel),
    .tap    (tap_word)
  );

  rdp_mask_dly #(.LANES(LANES), .DEPTH(MASK_D)) mask_i (
    .clk     (clk),
    .rst     (rst),
    .mask_in (byte_mask),
    .mask_out(mask_aged)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid   <= 1'b0;
      beat_idx   <= '0;
      lane_valid <= '0;
    end else begin
      rd_valid   <= tap_word[COL_W];
      beat_idx   <= tap_word[COL_W-1:0];
      lane_valid <= tap_word[COL_W] ? ~mask_aged : '0;
    end
  end

  p_first_beat_cl2_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_READ && !cas3) |=> ##2 (rd_valid && beat_idx == '0));

  p_first_beat_cl3_r1: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_READ && cas3) |=> ##3 (rd_valid && beat_idx == '0));

  p_beat_step_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(rd_valid) && beat_idx != '0) |->
      (beat_idx == $past(beat_idx) + 1'b1));

  p_lane_age_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (lane_valid == ~$past(byte_mask, 3)));

  p_lane_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (lane_valid == '0));

  p_bst_cut_cl2_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_BST && !cas3) |=> ##2 !rd_valid);

  p_bst_cut_cl3_r5: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_BST && cas3) |=> ##3 !rd_valid);

  p_pre_cut_cl2_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && !cas3) |=> ##2 !rd_valid);

  p_pre_cut_cl3_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PRE && cas3) |=> ##3 !rd_valid);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!rd_valid && lane_valid == '0 && beat_idx == '0));

endmodule

// File: tb/rdp_read_pipe_tb_top.sv
module rdp_read_pipe_tb_top;
  import sdr_rd_pkg::*;

  localparam int LANES = 2;
  localparam int COL_W = 9;
  localparam int PAGE  = 512;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       cmd = CMD_NOP;
  logic             cas3 = 1'b0;
  logic [2:0]       burst_code = 3'd0;
  logic [LANES-1:0] byte_mask = '0;
  logic             rd_valid;
  logic [LANES-1:0] lane_valid;
  logic [COL_W-1:0] beat_idx;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;
  logic [2:0] seq [0:1023];

  always #10 clk = ~clk;

  rdp_read_pipe #(.LANES(LANES), .COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .cmd(cmd), .cas3(cas3), .burst_code(burst_code),
    .byte_mask(byte_mask), .rd_valid(rd_valid), .lane_valid(lane_valid),
    .beat_idx(beat_idx)
  );

  function automatic logic [LANES-1:0] mask_of(int c, int seed);
    int v;
    v = (c + 16) * (seed * 2 + 3) + ((c + 16) >> 2);
    return LANES'(v);
  endfunction

  task automatic check(string tag, int e, logic ev, int eb, logic [LANES-1:0] el);
    n_chk++;
    if (rd_valid !== ev || (ev && beat_idx !== COL_W'(eb)) || lane_valid !== el) begin
      n_fail++;
      $display("FAIL %s edge %0d: got valid=%0b beat=%0d lanes=%b, expected valid=%0b beat=%0d lanes=%b",
               tag, e, rd_valid, beat_idx, lane_valid, ev, eb, el);
    end
  endtask

  task automatic clear_seq();
    for (int i = 0; i < 1024; i++) seq[i] = CMD_NOP;
  endtask

  // Output after edge e carries beat k = e-CL of the newest read at or
  // before k, unless a cutting command was registered between them.
  task automatic expect_at(int e, int len, int cl, logic [2:0] bc,
                           output logic ev, output int eb);
    int k, r, n;
    ev = 1'b0; eb = 0; r = -1;
    k = e - cl;
    if (k < 0) return;
    for (int c = 0; c <= k && c < len; c++) if (seq[c] == CMD_READ) r = c;
    if (r < 0) return;
    for (int c = r + 1; c <= k && c < len; c++)
      if (seq[c] == CMD_READ || seq[c] == CMD_BST || seq[c] == CMD_PRE) return;
    n = k - r;
    if (code_is_page(bc) || n < code_beats(bc)) begin
      ev = 1'b1;
      eb = n % PAGE;
    end
  endtask

  // Caller stands at a falling edge.
  task automatic run_seq(int len, int total, int seed, string tag);
    logic ev;
    int   eb;
    int   cl;
    cl = cas3 ? 3 : 2;
    for (int e = -4; e < total; e++) begin
      cmd       = (e >= 0 && e < len) ? seq[e] : CMD_NOP;
      byte_mask = mask_of(e, seed);
      @(posedge clk);
      @(negedge clk);
      if (e >= 0) begin
        expect_at(e, len, cl, burst_code, ev, eb);
        check(tag, e, ev, eb, ev ? ~mask_of(e - 2, seed) : '0);
      end
    end
    cmd = CMD_NOP;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got no end of run, expected finish before limit");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R9: outputs held clear while reset is high
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 reset state", 0, 1'b0, 0, '0);
    rst = 1'b0;

    for (int l = 0; l < 2; l++) begin
      cas3 = l[0];
      for (int b = 0; b < 4; b++) begin
        clear_seq();
        burst_code = 3'(b);
        seq[0] = CMD_READ;
        run_seq(1, (1 << b) + 6, b + l, "R1 R2 R3 R4 fixed burst");
      end

      clear_seq();
      burst_code = 3'd4;
      seq[0] = CMD_READ; seq[7] = CMD_BST;
      run_seq(8, 14, 5, "R5 burst stop cut");

      clear_seq();
      burst_code = 3'd7;
      seq[0] = CMD_READ; seq[5] = CMD_PRE;
      run_seq(6, 12, 6, "R6 precharge cut");

      clear_seq();
      burst_code = 3'd3;
      seq[0] = CMD_READ; seq[3] = CMD_READ;
      run_seq(4, 16, 7, "R7 read interrupts read");

      clear_seq();
      burst_code = 3'd3;
      seq[0] = CMD_READ; seq[7] = CMD_READ;
      run_seq(8, 20, 8, "R7 read at natural end");

      clear_seq();
      burst_code = 3'd0;
      for (int i = 0; i < 6; i++) seq[i] = CMD_READ;
      run_seq(6, 12, 9, "R7 read every clock");

      clear_seq();
      burst_code = 3'd2;
      seq[0] = CMD_BST; seq[1] = CMD_PRE; seq[2] = CMD_READ;
      seq[3] = 3'd4; seq[4] = 3'd5; seq[5] = 3'd6; seq[6] = 3'd7;
      run_seq(7, 14, 10, "R8 ignored codes");

      clear_seq();
      burst_code = 3'd4;
      seq[0] = CMD_READ; seq[515] = CMD_BST;
      run_seq(516, 523, 11, "R3 page wrap");
    end

    // R9: reset in the middle of a burst drops the pending beats
    cas3 = 1'b0;
    burst_code = 3'd3;
    byte_mask = '0;
    cmd = CMD_READ;
    @(posedge clk); @(negedge clk);
    cmd = CMD_NOP;
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    check("R1 beat before reset", 2, 1'b1, 0, 2'b11);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9 reset mid-burst", 3, 1'b0, 0, '0);
    rst = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); @(negedge clk);
      check("R9 no beat after reset", 4 + i, 1'b0, 0, '0);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule